// File: doc/BRIEF.md
# Parallel EEPROM Write and Completion Sequencer

This block is a clocked master for a byte-wide EEPROM that behaves like a static RAM on its bus. It takes one read or write command at a time on a valid/ready request port. It then produces the active-low chip select, output enable and write strobe. The setup time, strobe width and read access time are set in clock cycles. A read returns the sampled byte together with a one-cycle completion pulse.

After a write, the memory times its own internal programming cycle. The sequencer does not finish the command until that cycle has ended. It finds the end in one of two ways, chosen when the command is accepted:

- It reads the same address again and again until the top data bit matches the bit that was written. While the device is busy, that bit comes back inverted.
- It watches an open-drain ready line. That line needs a pull-up and may be shared by several devices.

A timeout ends a wait that takes too long. It is set above the worst-case write time of 200 us or 1 ms. On timeout the command completes with an error flag.

Back-pressure: `req_ready` is high only while the sequencer is idle. A request transfers on a rising edge where both `req_valid` and `req_ready` are high. A write is not considered finished until its completion has been confirmed or it has timed out. Until then no new request is taken, and a requester may hold `req_valid` high with its command stable.

Top module: `eewr_seq`

## Requirements
- R1: `req_ready` is 1 only in idle and 0 from the edge that accepts a command until the cycle in which `cmd_done` is 1; a request held during that time is taken only afterwards, in order.
- R2: A write holds `ee_ce_n`=0, `ee_oe_n`=1 and `ee_dq_oe`=1 for `cfg_setup` cycles before `ee_we_n` goes low. `ee_we_n` then stays low for `cfg_pulse` cycles, and address and data are held stable while it is low. One hold cycle with the data still driven follows. A setting of 0 acts as 1.
- R3: `ee_dq_oe` is 1 only in the write phases and is never 1 while `ee_oe_n` is 0.
- R4: A read drives `ee_ce_n`=0, `ee_oe_n`=0 and `ee_we_n`=1 for `cfg_access` cycles, with 0 acting as 1. It samples `ee_dq_in` on the last of those cycles and presents the byte on `rd_data` in the cycle where `cmd_done` is 1.
- R5: With `poll_mode`=1, completion is found by reads of the written address. Each read lasts `cfg_access` cycles and consecutive reads are separated by one cycle with `ee_ce_n`=1. The write completes when bit 7 of the read equals bit 7 of the written byte; the inverted value means busy.
- R6: With `poll_mode`=0, no reads take place during the wait. The ready line passes through two flops. After `BLANK` cycles, the write completes in the first cycle where the synchronized line is high.
- R7: If completion is not found within `TMO_CLKS` cycles of the start of the wait, the command ends with `cmd_done`=1 and `cmd_err`=1, and the sequencer returns to idle.
- R8: `cmd_done` is a one-cycle pulse per command and `cmd_err` is 1 only together with `cmd_done`.
- R9: The completion method is taken from `poll_mode` at acceptance; later changes of that input do not affect the command in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Command valid |
| req_ready | output | 1 | Command accepted when high with valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte address |
| req_wdata | input | 8 | Write data |
| poll_mode | input | 1 | 1 = bit-7 polling, 0 = ready line |
| cfg_setup | input | CW | Cycles from select to write strobe |
| cfg_pulse | input | CW | Write strobe width in cycles |
| cfg_access | input | CW | Read access time in cycles |
| cmd_done | output | 1 | Command finished (one cycle) |
| cmd_err | output | 1 | Finished by timeout |
| rd_data | output | 8 | Byte returned by a read |
| ee_addr | output | AW | Memory address bus |
| ee_dq_out | output | 8 | Data driven toward memory |
| ee_dq_oe | output | 1 | Data bus driver enable |
| ee_dq_in | input | 8 | Data read from memory |
| ee_ce_n | output | 1 | Chip select, active low |
| ee_oe_n | output | 1 | Output enable, active low |
| ee_we_n | output | 1 | Write strobe, active low |
| ee_rdy | input | 1 | Open-drain ready line, high = ready |

## Verification
The assertions check the bus rules on every cycle:

- the data driver is never enabled against the memory's outputs;
- the strobe is low only under chip select, with output enable high and stable address and data;
- `req_ready` appears only with the bus parked;
- the done and error flags behave as single pulses.

Cycle counts of setup, strobe and access phases, the polarity rule of the poll compare, the ready-line blanking, the timeout and the latching of the mode need scenario stimulus. Only the bench's directed scenarios, run against a behavioural memory model, show them.

// File: rtl/eewr_pkg.sv
package eewr_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WSET,
    ST_WPUL,
    ST_WHLD,
    ST_PACC,
    ST_PGAP,
    ST_BWAIT,
    ST_RACC
  } eewr_st_e;
endpackage

// File: rtl/eewr_cnt.sv
module eewr_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] ld_val,
  output logic         last
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (load)     cnt <= ld_val;
    else if (cnt > 1)  cnt <= cnt - 1'b1;
  end

  assign last = (cnt <= W'(1));
endmodule

// File: rtl/eewr_tmo.sv
module eewr_tmo #(
  parameter int LIMIT = 240000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic hit
);
  localparam int W = $clog2(LIMIT + 1);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr)        cnt <= '0;
    else if (run && !hit) cnt <= cnt + 1'b1;
  end

  assign hit = run && (cnt >= W'(LIMIT - 1));
endmodule

// File: rtl/eewr_sync.sv
module eewr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '1;
        else        sh <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '1;
        else        sh <= {sh[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sh[STAGES-1];
endmodule

// File: rtl/eewr_seq.sv
module eewr_seq
  import eewr_pkg::*;
#(
  parameter int AW       = 13,
  parameter int CW       = 4,
  parameter int TMO_CLKS = 240000,
  parameter int BLANK    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_wdata,
  input  logic          poll_mode,
  input  logic [CW-1:0] cfg_setup,
  input  logic [CW-1:0] cfg_pulse,
  input  logic [CW-1:0] cfg_access,
  output logic          cmd_done,
  output logic          cmd_err,
  output logic [7:0]    rd_data,
  output logic [AW-1:0] ee_addr,
  output logic [7:0]    ee_dq_out,
  output logic          ee_dq_oe,
  input  logic [7:0]    ee_dq_in,
  output logic          ee_ce_n,
  output logic          ee_oe_n,
  output logic          ee_we_n,
  input  logic          ee_rdy
);
  localparam int BW   = $clog2(BLANK + 1);
  localparam int CNTW = (CW > BW) ? CW : BW;

  eewr_st_e        state, nxt;
  logic [AW-1:0]   cmd_addr;
  logic [7:0]      cmd_data;
  logic            cmd_poll;
  logic            accept, ph_last, ph_load, tmo_hit, tmo_run, rdy_s;
  logic            fin, fin_err;
  logic [CNTW-1:0] ph_val;

  assign accept = req_valid && req_ready;

  // phase timer for setup, strobe, access and blanking
  eewr_cnt #(.W(CNTW)) ph_i (
    .clk(clk), .rst_n(rst_n), .load(ph_load), .ld_val(ph_val), .last(ph_last)
  );

  assign tmo_run = (state == ST_PACC) || (state == ST_PGAP) || (state == ST_BWAIT);
  eewr_tmo #(.LIMIT(TMO_CLKS)) tmo_i (
    .clk(clk), .rst_n(rst_n), .clr(state == ST_WHLD), .run(tmo_run), .hit(tmo_hit)
  );

  eewr_sync #(.STAGES(2)) rdy_i (
    .clk(clk), .rst_n(rst_n), .d(ee_rdy), .q(rdy_s)
  );

  always_comb begin
    nxt     = state;
    fin     = 1'b0;
    fin_err = 1'b0;
    unique case (state)
      ST_IDLE:  if (accept) nxt = req_write ? ST_WSET : ST_RACC;
      ST_WSET:  if (ph_last) nxt = ST_WPUL;
      ST_WPUL:  if (ph_last) nxt = ST_WHLD;
      ST_WHLD:  nxt = cmd_poll ? ST_PACC : ST_BWAIT;
      ST_PACC: begin
        if (ph_last && (ee_dq_in[7] == cmd_data[7])) begin
          nxt = ST_IDLE; fin = 1'b1;
        end else if (tmo_hit) begin
          nxt = ST_IDLE; fin = 1'b1; fin_err = 1'b1;
        end else if (ph_last) begin
          nxt = ST_PGAP;
        end
      end
      ST_PGAP: begin
        if (tmo_hit) begin
          nxt = ST_IDLE; fin = 1'b1; fin_err = 1'b1;
        end else begin
          nxt = ST_PACC;
        end
      end
      ST_BWAIT: begin
        if (ph_last && rdy_s) begin
          nxt = ST_IDLE; fin = 1'b1;
        end else if (tmo_hit) begin
          nxt = ST_IDLE; fin = 1'b1; fin_err = 1'b1;
        end
      end
      ST_RACC:  if (ph_last) begin nxt = ST_IDLE; fin = 1'b1; end
      default:  nxt = ST_IDLE;
    endcase
  end

  assign ph_load = (nxt != state);
  always_comb begin
    unique case (nxt)
      ST_WSET:          ph_val = CNTW'(cfg_setup);
      ST_WPUL:          ph_val = CNTW'(cfg_pulse);
      ST_PACC, ST_RACC: ph_val = CNTW'(cfg_access);
      ST_BWAIT:         ph_val = CNTW'(BLANK);
      default:          ph_val = CNTW'(1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cmd_addr <= '0;
      cmd_data <= '0;
      cmd_poll <= 1'b0;
      cmd_done <= 1'b0;
      cmd_err  <= 1'b0;
      rd_data  <= '0;
    end else begin
      state    <= nxt;
      cmd_done <= fin;
      cmd_err  <= fin_err;
      if (accept) begin
        cmd_addr <= req_addr;
        cmd_data <= req_wdata;
        cmd_poll <= poll_mode;
      end
      if (state == ST_RACC && ph_last) rd_data <= ee_dq_in;
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign ee_addr   = cmd_addr;
  assign ee_dq_out = cmd_data;
  assign ee_dq_oe  = (state == ST_WSET) || (state == ST_WPUL) || (state == ST_WHLD);
  assign ee_we_n   = (state != ST_WPUL);
  assign ee_oe_n   = !((state == ST_PACC) || (state == ST_RACC));
  assign ee_ce_n   = !(ee_dq_oe || !ee_oe_n);

  // R3
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ee_dq_oe && !ee_oe_n));

  // R2
  strobe_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ee_we_n |-> (!ee_ce_n && ee_oe_n && ee_dq_oe));

  // R2
  strobe_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ee_we_n && $past(!ee_we_n)) |-> ($stable(ee_addr) && $stable(ee_dq_out)));

  // R1
  ready_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ee_ce_n && ee_we_n && !ee_dq_oe));

  // R8
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> cmd_done);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> !cmd_done);
endmodule

// File: tb/eewr_seq_tb_top.sv
`timescale 1ns/1ps
module eewr_seq_tb_top;
  localparam int AW = 13;
  localparam int CW = 4;
  localparam int TMO = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          req_valid = 0, req_write = 0, poll_mode = 1;
  logic [AW-1:0] req_addr = '0;
  logic [7:0]    req_wdata = '0;
  logic [CW-1:0] cfg_setup = 4'd3, cfg_pulse = 4'd2, cfg_access = 4'd2;
  logic          req_ready, cmd_done, cmd_err, ee_dq_oe, ee_ce_n, ee_oe_n, ee_we_n;
  logic [7:0]    rd_data, ee_dq_out, ee_dq_in;
  logic [AW-1:0] ee_addr;
  logic          ee_rdy;

  eewr_seq #(.AW(AW), .CW(CW), .TMO_CLKS(TMO), .BLANK(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .poll_mode(poll_mode), .cfg_setup(cfg_setup), .cfg_pulse(cfg_pulse),
    .cfg_access(cfg_access), .cmd_done(cmd_done), .cmd_err(cmd_err),
    .rd_data(rd_data), .ee_addr(ee_addr), .ee_dq_out(ee_dq_out),
    .ee_dq_oe(ee_dq_oe), .ee_dq_in(ee_dq_in), .ee_ce_n(ee_ce_n),
    .ee_oe_n(ee_oe_n), .ee_we_n(ee_we_n), .ee_rdy(ee_rdy)
  );

  // behavioural memory: self-timed write, inverted bit 7 while busy
  logic [7:0] mem [16];
  int   busy_len = 20;
  int   busy = 0;
  logic we_q = 1'b1;
  logic b7 = 1'b0;
  always @(posedge clk) begin
    we_q <= ee_we_n;
    if (busy > 0) busy <= busy - 1;
    if (ee_we_n && !we_q && !ee_ce_n) begin
      mem[ee_addr[3:0]] <= ee_dq_out;
      b7   <= ee_dq_out[7];
      busy <= busy_len;
    end
  end
  assign ee_rdy   = (busy == 0);
  assign ee_dq_in = (ee_ce_n || ee_oe_n) ? 8'h00 :
                    (busy > 0) ? {~b7, 7'h2A} : mem[ee_addr[3:0]];

  // bus monitor
  logic mon_clr = 0;
  int   m_setup, m_we, m_we_pulses, m_oe_cyc, m_reads, m_badaddr, m_cont;
  logic m_we_seen, oe_q;
  logic [AW-1:0] exp_addr;
  always @(negedge clk) begin
    if (mon_clr) begin
      m_setup = 0; m_we = 0; m_we_pulses = 0; m_oe_cyc = 0; m_reads = 0;
      m_badaddr = 0; m_cont = 0; m_we_seen = 0; oe_q = 1;
    end else begin
      if (!ee_ce_n && ee_we_n && ee_oe_n && ee_dq_oe && !m_we_seen) m_setup++;
      if (!ee_we_n) begin
        if (!m_we_seen) m_we_pulses++;
        m_we++; m_we_seen = 1;
      end
      if (!ee_oe_n) begin
        m_oe_cyc++;
        if (oe_q) m_reads++;
        if (ee_addr != exp_addr) m_badaddr++;
      end
      if (!ee_oe_n && ee_dq_oe) m_cont++;
      oe_q = ee_oe_n;
    end
  end

  int n_chk = 0, n_err = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // issue one command and wait for its completion
  task automatic run_cmd(input bit wr, input logic [AW-1:0] a, input logic [7:0] d,
                         input bit pm, output logic [7:0] rd, output bit err,
                         output int cyc, output bit rdy_at_done);
    @(negedge clk);
    mon_clr = 1; exp_addr = a;
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; poll_mode = pm;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    mon_clr = 0; req_valid = 0;
    cyc = 1;
    while (!cmd_done && cyc < 5000) begin @(negedge clk); cyc++; end
    rd = rd_data; err = cmd_err; rdy_at_done = ee_rdy;
  endtask

  logic [7:0] rd;
  bit err, rz;
  int cyc;

  task automatic t_reset();
    chk(req_ready && ee_ce_n && ee_oe_n && ee_we_n && !ee_dq_oe && !cmd_done,
        "R1 reset idle", {req_ready, ee_ce_n, ee_oe_n, ee_we_n, ee_dq_oe, cmd_done}, 6'b111100);
  endtask

  task automatic t_write_poll();
    cfg_setup = 3; cfg_pulse = 2; cfg_access = 2; busy_len = 40;
    run_cmd(1, 13'h0003, 8'hA5, 1, rd, err, cyc, rz);
    chk(m_setup == 3, "R2 setup cycles", m_setup, 3);
    chk(m_we == 2, "R2 strobe cycles", m_we, 2);
    chk(m_reads >= 2, "R5 repeated poll reads", m_reads, 2);
    chk(m_oe_cyc == 2 * m_reads, "R5 poll read length", m_oe_cyc, 2 * m_reads);
    chk(m_badaddr == 0, "R5 poll address", m_badaddr, 0);
    chk(!err && rz, "R5 done after busy ends (bit7=1)", {err, rz}, 2'b01);
    chk(m_cont == 0, "R3 no contention", m_cont, 0);
  endtask

  task automatic t_read();
    cfg_access = 3;
    run_cmd(0, 13'h0003, 8'h00, 1, rd, err, cyc, rz);
    chk(rd == 8'hA5, "R4 read data", rd, 8'hA5);
    chk(m_oe_cyc == 3, "R4 access cycles", m_oe_cyc, 3);
    chk(m_we == 0 && !err, "R4 no strobe on read", m_we, 0);
  endtask

  task automatic t_write_busy();
    cfg_setup = 2; cfg_pulse = 3; busy_len = 30;
    run_cmd(1, 13'h0005, 8'h3C, 0, rd, err, cyc, rz);
    chk(m_oe_cyc == 0, "R6 no reads in ready-line mode", m_oe_cyc, 0);
    chk(!err && rz, "R6 done after ready high", {err, rz}, 2'b01);
    chk(cyc >= 30, "R6 waited for busy", cyc, 30);
    chk(m_we == 3, "R2 strobe cycles 3", m_we, 3);
  endtask

  task automatic t_zero_cfg();
    cfg_setup = 0; cfg_pulse = 0; cfg_access = 0; busy_len = 10;
    run_cmd(1, 13'h0007, 8'h11, 1, rd, err, cyc, rz);
    chk(m_setup == 1, "R2 zero setup acts as 1", m_setup, 1);
    chk(m_we == 1, "R2 zero strobe acts as 1", m_we, 1);
    chk(!err && rz, "R5 done with bit7=0 data", {err, rz}, 2'b01);
    run_cmd(0, 13'h0007, 8'h00, 1, rd, err, cyc, rz);
    chk(rd == 8'h11 && m_oe_cyc == 1, "R4 zero access acts as 1", m_oe_cyc, 1);
    cfg_setup = 2; cfg_pulse = 2; cfg_access = 2;
  endtask

  task automatic t_timeout(input bit pm, input string tag);
    busy_len = 1000;
    run_cmd(1, 13'h0009, 8'h80, pm, rd, err, cyc, rz);
    chk(err, tag, err, 1);
    chk(cyc >= TMO && cyc < TMO + 40, "R7 timeout window", cyc, TMO);
    @(negedge clk);
    chk(req_ready && !cmd_done, "R8 idle after timeout, single pulse",
        {req_ready, cmd_done}, 2'b10);
    repeat (800) @(negedge clk);
  endtask

  task automatic t_stall();
    int readies, we_before;
    busy_len = 25;
    @(negedge clk);
    mon_clr = 1; exp_addr = 13'h000A;
    req_valid = 1; req_write = 1; req_addr = 13'h000A; req_wdata = 8'h5E; poll_mode = 1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    mon_clr = 0;
    req_write = 0; req_wdata = 8'h00;
    readies = 0;
    for (int i = 0; i < 5000 && !cmd_done; i++) begin
      if (req_ready) readies++;
      @(negedge clk);
    end
    we_before = m_we_pulses;
    chk(readies == 0, "R1 stalled while write pending", readies, 0);
    chk(we_before == 1, "R1 single write before done", we_before, 1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    cyc = 0;
    while (!cmd_done && cyc < 5000) begin @(negedge clk); cyc++; end
    chk(rd_data == 8'h5E, "R1 held read taken after write", rd_data, 8'h5E);
  endtask

  task automatic t_mode_latch();
    busy_len = 30;
    @(negedge clk);
    mon_clr = 1; exp_addr = 13'h000C;
    req_valid = 1; req_write = 1; req_addr = 13'h000C; req_wdata = 8'h77; poll_mode = 0;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    mon_clr = 0; req_valid = 0; poll_mode = 1;
    cyc = 0;
    while (!cmd_done && cyc < 5000) begin @(negedge clk); cyc++; end
    chk(m_oe_cyc == 0, "R9 mode latched at accept", m_oe_cyc, 0);
    chk(!cmd_err, "R9 completes without error", cmd_err, 0);
  endtask

  initial begin
    #(200000 * 5);
    n_err++; n_chk++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_write_poll();
    t_read();
    t_write_busy();
    t_zero_cfg();
    t_timeout(1, "R7 timeout in poll mode");
    t_timeout(0, "R7 timeout in ready-line mode");
    t_stall();
    t_mode_latch();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule